// File: doc/BRIEF.md
# ADC Input Multiplexer Sequencer

This block steps a four-slot analog input multiplexer in front of one shared delta-sigma converter. It runs in the system clock domain and advances on a 32.768 kHz tick enable. The compute engine launches each frame with a start strobe. The sequencer then visits mux slots 0 to 3 in turn. For each slot it drives the channel select, issues a convert-start pulse on the next tick, and waits until the conversion has lasted a full two tick periods. It then takes the converter's done pulse and its result, and writes the result to a data-RAM address fixed by the slot.

Normal frames sample the four external inputs. The processor can arm an alternate frame with a single request pulse. That frame replaces slot 0 with the die-temperature sensor and slot 2 with the digital supply monitor. The request is used up by one frame, and later frames return to the normal sequence. Both frame types write the same four RAM addresses.

Top module: `adc_mux_seq`

## Requirements
- R1: With the block idle, a start_i pulse begins a frame, and busy_o is high from the next cycle until the cycle after the slot-3 result is accepted.
- R2: In a regular frame, sel_o carries code k in slot k (A0=0, A1=1, A2=2, A3=3). While idle, sel_o is 0.
- R3: In an alternate frame, sel_o carries, for slots 0 to 3, TEMP=4, A1=1, SUPPLY=5, A3=3.
- R4: conv_start_o is a single-cycle pulse. It is raised in the cycle after the first tick_i that the block samples once a slot is entered, and never in the same cycle as wr_en_o.
- R5: conv_done_i is accepted only after CONV_TICKS (default 2) ticks have been sampled since conv_start_o. An earlier done is ignored and writes nothing. slot and sel_o hold steady until acceptance.
- R6: In the cycle after an accepted done, wr_en_o is high for one cycle, wr_addr_o = BASE_ADDR + slot, and wr_data_o = the accepted conv_data_i. Alternate frames use the same addresses.
- R7: frame_done_o pulses in the same cycle as the slot-3 write, and the block is then idle.
- R8: A start_i that arrives while a frame is in progress is ignored: no frame follows it once the current frame ends.
- R9: An alt_req_i pulse arms exactly the next frame started after the request cycle, and only that frame. A request in the same cycle as an accepted start applies to the frame after that one.
- R10: After reset the block is idle with no alternate frame armed, and conv_start_o, wr_en_o and frame_done_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | 32.768 kHz tick enable, one cycle wide |
| start_i | input | 1 | Frame start strobe from the compute engine |
| alt_req_i | input | 1 | Processor request for one alternate frame |
| conv_done_i | input | 1 | Converter result-ready pulse |
| conv_data_i | input | DATA_W | Converter result |
| conv_start_o | output | 1 | Convert-start pulse to the converter |
| sel_o | output | 3 | Mux channel select code |
| busy_o | output | 1 | Frame in progress |
| wr_en_o | output | 1 | Data-RAM write strobe |
| wr_addr_o | output | ADDR_W | Data-RAM write address |
| wr_data_o | output | DATA_W | Data-RAM write data |
| frame_done_o | output | 1 | Pulse after the last slot is written |

## Verification
The in-line assertions check the cycle-level rules on every cycle:
- the slot holds while a conversion is waiting;
- a premature done causes no move;
- convert-start follows a sampled tick in the arm state;
- writes stay inside the four-address window;
- frame-done coincides with the last-slot write;
- a consumed alternate request clears.

Only the bench scenarios can show the properties that involve a whole frame. These are the exact select order of each frame type, the single-frame lifetime of a request (including one that lands on the start cycle or mid-frame), that a mid-frame start produces no extra frame, and that early converter pulses never corrupt the stored data.

// File: rtl/adc_mux_seq_pkg.sv
package adc_mux_seq_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ARM  = 2'd1,
    ST_CONV = 2'd2
  } seq_state_e;

  localparam logic [2:0] SEL_TEMP   = 3'd4;
  localparam logic [2:0] SEL_SUPPLY = 3'd5;

  function automatic logic [2:0] reg_code(input int unsigned s);
    return 3'(s);
  endfunction

  function automatic logic [2:0] alt_code(input int unsigned s);
    case (s)
      0:       return SEL_TEMP;
      2:       return SEL_SUPPLY;
      default: return reg_code(s);
    endcase
  endfunction

endpackage

// File: rtl/adc_seq_arm.sv
module adc_seq_arm (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  input  logic consume_i,
  output logic pend_o
);

  logic pend_q;

  // a request landing on the consume cycle survives for the following frame
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= 1'b0;
    else         pend_q <= (pend_q & ~consume_i) | req_i;
  end

  assign pend_o = pend_q;

  assert_consume_clears_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (consume_i && !req_i) |=> !pend_q);

  assert_req_arms_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> pend_q);

endmodule

// File: rtl/adc_seq_selmap.sv
module adc_seq_selmap #(
  parameter int unsigned SLOTS  = 4,
  localparam int unsigned SLOT_W = $clog2(SLOTS)
) (
  input  logic              alt_i,
  input  logic [SLOT_W-1:0] slot_i,
  output logic [2:0]        sel_o
);
  import adc_mux_seq_pkg::*;

  logic [2:0] reg_tab [SLOTS];
  logic [2:0] alt_tab [SLOTS];

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    assign reg_tab[s] = reg_code(s);
    assign alt_tab[s] = alt_code(s);
  end

  assign sel_o = alt_i ? alt_tab[slot_i] : reg_tab[slot_i];

endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl #(
  parameter int unsigned SLOTS      = 4,
  parameter int unsigned CONV_TICKS = 2,
  localparam int unsigned SLOT_W    = $clog2(SLOTS),
  localparam int unsigned CNT_W     = $clog2(CONV_TICKS + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              start_i,
  input  logic              done_i,
  input  logic              pend_i,
  output logic              consume_o,
  output logic              accept_o,
  output logic              last_o,
  output logic              conv_start_o,
  output logic              busy_o,
  output logic [SLOT_W-1:0] slot_o,
  output logic              alt_o
);
  import adc_mux_seq_pkg::*;

  localparam logic [CNT_W-1:0]  TICKS_FULL = CNT_W'(CONV_TICKS);
  localparam logic [SLOT_W-1:0] SLOT_LAST  = SLOT_W'(SLOTS - 1);

  seq_state_e        state_q;
  logic [SLOT_W-1:0] slot_q;
  logic              alt_q;
  logic [CNT_W-1:0]  tcnt_q;
  logic              cs_q;
  logic              ticks_met;

  assign ticks_met = (tcnt_q == TICKS_FULL);
  assign accept_o  = (state_q == ST_CONV) && done_i && ticks_met;
  assign last_o    = (slot_q == SLOT_LAST);
  assign consume_o = (state_q == ST_IDLE) && start_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      slot_q  <= '0;
      alt_q   <= 1'b0;
      tcnt_q  <= '0;
      cs_q    <= 1'b0;
    end else begin
      cs_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          state_q <= ST_ARM;
          slot_q  <= '0;
          alt_q   <= pend_i;
        end
        ST_ARM: if (tick_i) begin
          cs_q    <= 1'b1;
          state_q <= ST_CONV;
          tcnt_q  <= '0;
        end
        ST_CONV: begin
          if (accept_o) begin
            if (last_o) begin
              state_q <= ST_IDLE;
              slot_q  <= '0;
              alt_q   <= 1'b0;
            end else begin
              slot_q  <= slot_q + 1'b1;
              state_q <= ST_ARM;
            end
          end else if (tick_i && !ticks_met) begin
            tcnt_q <= tcnt_q + 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign conv_start_o = cs_q;
  assign busy_o       = (state_q != ST_IDLE);
  assign slot_o       = slot_q;
  assign alt_o        = alt_q;

  assert_sel_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_CONV && !accept_o) |=> ($stable(slot_q) && $stable(alt_q)));

  assert_no_early_accept_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_CONV && done_i && tcnt_q < TICKS_FULL) |=> (state_q == ST_CONV));

  assert_cs_after_tick_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_ARM && tick_i) |=> (cs_q && state_q == ST_CONV));

  assert_cs_single_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_q |=> !cs_q);

endmodule

// File: rtl/adc_seq_wrport.sv
module adc_seq_wrport #(
  parameter int unsigned SLOTS     = 4,
  parameter int unsigned DATA_W    = 22,
  parameter int unsigned ADDR_W    = 7,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 7'h10,
  localparam int unsigned SLOT_W   = $clog2(SLOTS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              accept_i,
  input  logic              last_i,
  input  logic [SLOT_W-1:0] slot_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              wr_en_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [DATA_W-1:0] wr_data_o,
  output logic              frame_done_o
);

  localparam logic [ADDR_W-1:0] SPAN = ADDR_W'(SLOTS);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_en_o      <= 1'b0;
      wr_addr_o    <= '0;
      wr_data_o    <= '0;
      frame_done_o <= 1'b0;
    end else begin
      wr_en_o      <= accept_i;
      frame_done_o <= accept_i && last_i;
      if (accept_i) begin
        wr_addr_o <= BASE_ADDR + ADDR_W'(slot_i);
        wr_data_o <= data_i;
      end
    end
  end

  assert_addr_window_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> ((wr_addr_o - BASE_ADDR) < SPAN));

  assert_done_on_last_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_done_o |-> (wr_en_o && wr_addr_o == BASE_ADDR + SPAN - 1'b1));

endmodule

// File: rtl/adc_mux_seq.sv
module adc_mux_seq #(
  parameter int unsigned SLOTS      = 4,
  parameter int unsigned CONV_TICKS = 2,
  parameter int unsigned DATA_W     = 22,
  parameter int unsigned ADDR_W     = 7,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 7'h10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              start_i,
  input  logic              alt_req_i,
  input  logic              conv_done_i,
  input  logic [DATA_W-1:0] conv_data_i,
  output logic              conv_start_o,
  output logic [2:0]        sel_o,
  output logic              busy_o,
  output logic              wr_en_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [DATA_W-1:0] wr_data_o,
  output logic              frame_done_o
);

  localparam int unsigned SLOT_W = $clog2(SLOTS);

  logic              pend, consume, accept, last, alt;
  logic [SLOT_W-1:0] slot;

  adc_seq_arm u_arm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .req_i     (alt_req_i),
    .consume_i (consume),
    .pend_o    (pend)
  );

  adc_seq_ctrl #(.SLOTS(SLOTS), .CONV_TICKS(CONV_TICKS)) u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .tick_i       (tick_i),
    .start_i      (start_i),
    .done_i       (conv_done_i),
    .pend_i       (pend),
    .consume_o    (consume),
    .accept_o     (accept),
    .last_o       (last),
    .conv_start_o (conv_start_o),
    .busy_o       (busy_o),
    .slot_o       (slot),
    .alt_o        (alt)
  );

  adc_seq_selmap #(.SLOTS(SLOTS)) u_selmap (
    .alt_i  (alt),
    .slot_i (slot),
    .sel_o  (sel_o)
  );

  adc_seq_wrport #(
    .SLOTS(SLOTS), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)
  ) u_wrport (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .accept_i     (accept),
    .last_i       (last),
    .slot_i       (slot),
    .data_i       (conv_data_i),
    .wr_en_o      (wr_en_o),
    .wr_addr_o    (wr_addr_o),
    .wr_data_o    (wr_data_o),
    .frame_done_o (frame_done_o)
  );

  assert_one_event_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({conv_start_o, wr_en_o}));

  assert_idle_after_done_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_done_o |-> !busy_o);

endmodule

// File: tb/adc_mux_seq_bench.sv
`timescale 1ns/1ps
module adc_mux_seq_bench;

  localparam int DW = 22;
  localparam int AW = 7;
  localparam int BASE = 'h10;
  localparam int TICK_DIV = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0, start = 1'b0, alt_req = 1'b0, done = 1'b0;
  logic [DW-1:0] cdata = '0;
  logic cs, busy, we, fd;
  logic [2:0] sel;
  logic [AW-1:0] waddr;
  logic [DW-1:0] wdata;

  always #5 clk = ~clk;

  adc_mux_seq u_adc_mux_seq (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .start_i(start),
    .alt_req_i(alt_req), .conv_done_i(done), .conv_data_i(cdata),
    .conv_start_o(cs), .sel_o(sel), .busy_o(busy), .wr_en_o(we),
    .wr_addr_o(waddr), .wr_data_o(wdata), .frame_done_o(fd)
  );

  int checks = 0, fails = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int exp_sel(input bit a, input int s);
    if (!a) return s;
    case (s) 0: return 4; 2: return 5; default: return s; endcase
  endfunction

  // tick source and converter model
  int  tdiv = 0, cv_ticks = 0, cv_glitch = 0;
  bit  cv_active = 0, early_mode = 0, cv_fire = 0;
  always @(negedge clk) begin
    done <= 1'b0;
    if (cv_fire) begin
      done <= 1'b1; cdata <= cdata + 22'h1235; cv_fire = 0; cv_active = 0;
    end
    if (cs) begin
      cv_active = 1; cv_ticks = 0; cv_glitch = early_mode ? 2 : 0;
    end
    if (cv_glitch > 0) begin
      cv_glitch--;
      if (cv_glitch == 0) done <= 1'b1;
    end
    tdiv = (tdiv + 1) % TICK_DIV;
    tick <= (tdiv == 0);
    if (tdiv == 0 && cv_active) begin
      cv_ticks++;
      if (cv_ticks == 2) cv_fire = 1;
    end
  end

  // behavioural reference, stepped on every rising edge
  int m_st = 0, m_slot = 0, m_tk = 0;
  bit m_alt = 0, m_pend = 0;
  bit e_cs = 0, e_we = 0, e_fd = 0;
  int e_addr = 0, e_data = 0;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; m_slot = 0; m_tk = 0; m_alt = 0; m_pend = 0;
      e_cs = 0; e_we = 0; e_fd = 0; e_addr = 0; e_data = 0;
    end else begin
      bit np;
      np = m_pend;
      e_cs = 0; e_we = 0; e_fd = 0;
      if (m_st == 0) begin
        if (start) begin m_st = 1; m_slot = 0; m_alt = m_pend; np = 0; end
      end else if (m_st == 1) begin
        if (tick) begin e_cs = 1; m_st = 2; m_tk = 0; end
      end else begin
        if (done && m_tk >= 2) begin
          e_we = 1; e_addr = BASE + m_slot; e_data = int'(cdata);
          if (m_slot == 3) begin e_fd = 1; m_st = 0; m_slot = 0; m_alt = 0; end
          else begin m_slot++; m_st = 1; end
        end else if (tick && m_tk < 2) m_tk++;
      end
      if (alt_req) np = 1;
      m_pend = np;
    end
  end

  always @(negedge clk) if (rst_n) begin
    chk(busy == (m_st != 0), "R1 busy", int'(busy), int'(m_st != 0));
    chk(int'(sel) == exp_sel(m_alt, m_slot), m_alt ? "R3 sel" : "R2 sel", int'(sel), exp_sel(m_alt, m_slot));
    chk(cs == e_cs, "R4 conv_start", int'(cs), int'(e_cs));
    chk(we == e_we, "R5 wr_en", int'(we), int'(e_we));
    if (e_we) begin
      chk(int'(waddr) == e_addr, "R6 addr", int'(waddr), e_addr);
      chk(int'(wdata) == e_data, "R6 data", int'(wdata), e_data);
    end
    chk(fd == e_fd, "R7 frame_done", int'(fd), int'(e_fd));
  end

  // frame-level capture
  int sel_log[4], addr_log[4];
  int n_cs = 0, n_wr = 0, n_fd = 0;
  always @(negedge clk) if (rst_n) begin
    if (cs && n_cs < 4) begin sel_log[n_cs] = int'(sel); n_cs++; end
    if (we && n_wr < 4) begin addr_log[n_wr] = int'(waddr); n_wr++; end
    if (fd) n_fd++;
  end

  task automatic pulse_start(input bit with_req);
    @(negedge clk); start <= 1'b1; alt_req <= with_req;
    @(negedge clk); start <= 1'b0; alt_req <= 1'b0;
  endtask

  task automatic pulse_req();
    @(negedge clk); alt_req <= 1'b1;
    @(negedge clk); alt_req <= 1'b0;
  endtask

  task automatic run_frame(input bit exp_alt, input bit mid_start, input bit mid_req,
                           input bit req_on_start);
    int fd0, guard;
    n_cs = 0; n_wr = 0; fd0 = n_fd; guard = 0;
    pulse_start(req_on_start);
    chk(busy == 1'b1, "R1 busy after start", int'(busy), 1);
    while (n_fd == fd0 && guard < 2000) begin
      @(negedge clk); guard++;
      if (guard == 30 && mid_start) begin start <= 1'b1; @(negedge clk); start <= 1'b0; end
      if (guard == 40 && mid_req) begin alt_req <= 1'b1; @(negedge clk); alt_req <= 1'b0; end
    end
    chk(guard < 2000, "R7 frame completes", guard, 0);
    chk(n_wr == 4, "R6 write count", n_wr, 4);
    for (int s = 0; s < 4; s++) begin
      chk(sel_log[s] == exp_sel(exp_alt, s), exp_alt ? "R3 slot sel" : "R2 slot sel",
          sel_log[s], exp_sel(exp_alt, s));
      chk(addr_log[s] == BASE + s, "R6 slot addr", addr_log[s], BASE + s);
    end
    repeat (20) @(negedge clk);
    chk(busy == 1'b0, "R8 no extra frame", int'(busy), 0);
    chk(n_cs == 4, "R8 conv count", n_cs, 4);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(busy == 0 && cs == 0 && we == 0 && fd == 0, "R10 reset outputs",
        int'({busy, cs, we, fd}), 0);
    rst_n <= 1'b1;
    repeat (4) @(negedge clk);
    chk(int'(sel) == 0, "R2 idle sel", int'(sel), 0);
    run_frame(0, 0, 0, 0);                 // R1 R2 R6 R7 regular
    pulse_req();
    run_frame(1, 0, 0, 0);                 // R3 R9 alternate armed once
    run_frame(0, 1, 0, 0);                 // R9 reverted, R8 mid-frame start
    early_mode = 1;
    run_frame(0, 0, 0, 0);                 // R5 early done pulses ignored
    early_mode = 0;
    run_frame(0, 0, 0, 1);                 // R9 request on start cycle deferred
    run_frame(1, 0, 1, 0);                 // deferred request used; mid-frame request armed
    run_frame(1, 0, 0, 0);                 // R9 mid-frame request applies here
    run_frame(0, 0, 0, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule